// File: doc/BRIEF.md
# Pipelined Integer Square Root (Subtract-Only Array)

This block computes the unsigned integer square root of an even-width radicand, together with the remainder left over. It is built as a fully pipelined array. Each pipeline stage produces one bit of the root, so the root width sets both the number of stages and the latency. Each stage is one row of borrow-chained cells. A row takes the partial remainder with the next two radicand bits brought down and subtracts a trial value from it. The trial value is the partial root with binary 01 appended. When the row's final borrow shows the difference is non-negative, each cell passes the difference bit and the new root bit is 1. Otherwise each cell passes its original minuend bit, which keeps the old remainder without any restore addition, and the new root bit is 0. No stage ever adds or appends 11.

A host presents a radicand with a valid strobe on any clock, including every clock in a row. Exactly `RAD_W/2` clocks later the result appears with its own valid strobe. The width is set by parameter, and 32 and 64 bits are typical.

Top module: `sqrt_pipe`

## Requirements
- R1: `res_root` equals floor(sqrt(x)) for the radicand x that entered with the matching strobe.
- R2: `res_rem` equals x - root*root and never exceeds 2*root.
- R3: `res_vld` equals `op_vld` delayed by exactly `RAD_W/2` clock edges, provided no reset edge falls in that window.
- R4: A new operand is accepted on every clock. A run of back-to-back strobes yields the same number of back-to-back results.
- R5: A clock edge with `rst` high clears every stage's valid bit. `res_vld` is low after that edge and stays low until a strobe taken after reset reaches the output.
- R6: A radicand presented while `op_vld` is low produces no result strobe.
- R7: Boundary operands give these results. Zero gives root 0 and remainder 0. The radicand 93 gives root 9 and remainder 12. The all-ones radicand gives root 2^(RAD_W/2)-1 and remainder 2^(RAD_W/2+1)-2.
- R8: A perfect square k*k gives root k and remainder 0. The value one below it gives root k-1 and remainder 2k-2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of valid bits |
| op_vld | input | 1 | Radicand strobe |
| op_rad | input | RAD_W | Unsigned radicand |
| res_vld | output | 1 | Result strobe |
| res_root | output | RAD_W/2 | Integer square root |
| res_rem | output | RAD_W/2+2 | Remainder x - root*root |

## Verification
The checker keeps its own record of the strobes and radicands that entered, and the arithmetic assertions read that record. They therefore assume `op_rad` is stable and defined in every cycle where `op_vld` is high, and that reset is a synchronous level sampled on the clock. The stimulus drives both inputs only on the falling clock edge and always applies a defined radicand, even when the strobe is low. It asserts reset once at start and once with the pipe full. The random stimulus mixes in squares and their neighbours, so that both borrow outcomes occur in every row.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;
    localparam int DEF_RAD_W = 32;

    function automatic int root_width(input int rad_w);
        return rad_w / 2;
    endfunction

    function automatic int rem_width(input int rad_w);
        return rad_w / 2 + 2;
    endfunction
endpackage

// File: rtl/sqrt_csm_cell.sv
module sqrt_csm_cell (
    input  logic x,
    input  logic y,
    input  logic b,
    input  logic u,
    output logic bo,
    output logic d
);
    logic diff;
    always_comb begin
        diff = x ^ y ^ b;
        bo   = (~x & y) | (~(x ^ y) & b);
        d    = u ? diff : x;
    end
endmodule

// File: rtl/sqrt_borrow_cell.sv
module sqrt_borrow_cell (
    input  logic x,
    input  logic y,
    input  logic b,
    output logic bo
);
    always_comb bo = (~x & y) | (~(x ^ y) & b);
endmodule

// File: rtl/sqrt_csm_row.sv
module sqrt_csm_row #(
    parameter int W     = 20,
    parameter int OUT_W = 18
) (
    input  logic [W-1:0]     minu,
    input  logic [W-1:0]     subt,
    output logic [OUT_W-1:0] res,
    output logic             keep_n
);
    logic [W:0] brw;
    logic       sel;

    assign brw[0] = 1'b0;
    assign sel    = ~brw[W];
    assign keep_n = sel;

    for (genvar i = 0; i < W; i++) begin : g_cell
        if (i < OUT_W) begin : g_full
            sqrt_csm_cell u_cell (
                .x (minu[i]),
                .y (subt[i]),
                .b (brw[i]),
                .u (sel),
                .bo(brw[i+1]),
                .d (res[i])
            );
        end else begin : g_top
            sqrt_borrow_cell u_cell (
                .x (minu[i]),
                .y (subt[i]),
                .b (brw[i]),
                .bo(brw[i+1])
            );
        end
    end
endmodule

// File: rtl/sqrt_stage.sv
module sqrt_stage #(
    parameter int RAD_W = 32,
    localparam int ROOT_W = RAD_W / 2,
    localparam int REM_W  = ROOT_W + 2,
    localparam int ROW_W  = REM_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [RAD_W-1:0]  in_rad,
    input  logic [ROOT_W-1:0] in_root,
    input  logic [REM_W-1:0]  in_rem,
    output logic              out_vld,
    output logic [RAD_W-1:0]  out_rad,
    output logic [ROOT_W-1:0] out_root,
    output logic [REM_W-1:0]  out_rem
);
    typedef struct packed {
        logic              vld;
        logic [RAD_W-1:0]  rad;
        logic [ROOT_W-1:0] root;
        logic [REM_W-1:0]  rem;
    } stage_t;

    stage_t             st_d, st_q;
    logic [ROW_W-1:0]   minu, subt;
    logic [REM_W-1:0]   row_res;
    logic               bit_new;

    always_comb begin
        minu = {in_rem, in_rad[RAD_W-1 -: 2]};
        subt = {2'b00, in_root, 2'b01};
    end

    sqrt_csm_row #(.W(ROW_W), .OUT_W(REM_W)) u_row (
        .minu  (minu),
        .subt  (subt),
        .res   (row_res),
        .keep_n(bit_new)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = in_vld;
        st_d.rad  = {in_rad[RAD_W-3:0], 2'b00};
        st_d.root = {in_root[ROOT_W-2:0], bit_new};
        st_d.rem  = row_res;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.vld <= 1'b0;
        else     st_q.vld <= st_d.vld;
        st_q.rad  <= st_d.rad;
        st_q.root <= st_d.root;
        st_q.rem  <= st_d.rem;
    end

    assign out_vld  = st_q.vld;
    assign out_rad  = st_q.rad;
    assign out_root = st_q.root;
    assign out_rem  = st_q.rem;
endmodule

// File: rtl/sqrt_pipe.sv
module sqrt_pipe
    import sqrt_pkg::*;
#(
    parameter int RAD_W = DEF_RAD_W,
    localparam int ROOT_W = root_width(RAD_W),
    localparam int REM_W  = rem_width(RAD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_vld,
    input  logic [RAD_W-1:0]  op_rad,
    output logic              res_vld,
    output logic [ROOT_W-1:0] res_root,
    output logic [REM_W-1:0]  res_rem
);
    logic              vld_c  [ROOT_W+1];
    logic [RAD_W-1:0]  rad_c  [ROOT_W+1];
    logic [ROOT_W-1:0] root_c [ROOT_W+1];
    logic [REM_W-1:0]  rem_c  [ROOT_W+1];

    assign vld_c[0]  = op_vld;
    assign rad_c[0]  = op_rad;
    assign root_c[0] = '0;
    assign rem_c[0]  = '0;

    for (genvar k = 0; k < ROOT_W; k++) begin : g_stage
        sqrt_stage #(.RAD_W(RAD_W)) u_stage (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (vld_c[k]),
            .in_rad  (rad_c[k]),
            .in_root (root_c[k]),
            .in_rem  (rem_c[k]),
            .out_vld (vld_c[k+1]),
            .out_rad (rad_c[k+1]),
            .out_root(root_c[k+1]),
            .out_rem (rem_c[k+1])
        );
    end

    assign res_vld  = vld_c[ROOT_W];
    assign res_root = root_c[ROOT_W];
    assign res_rem  = rem_c[ROOT_W];
endmodule

// File: rtl/sqrt_pipe_chk.sv
module sqrt_pipe_chk #(
    parameter int RAD_W = 32,
    localparam int ROOT_W = RAD_W / 2,
    localparam int REM_W  = ROOT_W + 2,
    localparam int SUM_W  = RAD_W + 2
) (
    input logic              clk,
    input logic              rst,
    input logic              op_vld,
    input logic [RAD_W-1:0]  op_rad,
    input logic              res_vld,
    input logic [ROOT_W-1:0] res_root,
    input logic [REM_W-1:0]  res_rem
);
    logic [ROOT_W-1:0] vld_sh;
    logic [RAD_W-1:0]  rad_sh [ROOT_W];
    logic [SUM_W-1:0]  sq_sum, twice_root;

    always_ff @(posedge clk) begin
        if (rst) vld_sh <= '0;
        else     vld_sh <= {vld_sh[ROOT_W-2:0], op_vld};
        rad_sh[0] <= op_rad;
        for (int i = 1; i < ROOT_W; i++) rad_sh[i] <= rad_sh[i-1];
    end

    always_comb begin
        sq_sum     = SUM_W'(res_root) * SUM_W'(res_root) + SUM_W'(res_rem);
        twice_root = SUM_W'(res_root) << 1;
    end

    assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
        res_vld == vld_sh[ROOT_W-1]);

    assert_square_sum_R1: assert property (@(posedge clk) disable iff (rst)
        (res_vld && vld_sh[ROOT_W-1]) |-> sq_sum == SUM_W'(rad_sh[ROOT_W-1]));

    assert_rem_bound_R2: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> SUM_W'(res_rem) <= twice_root);

    assert_reset_clears_R5: assert property (@(posedge clk)
        rst |=> !res_vld);
endmodule

bind sqrt_pipe sqrt_pipe_chk #(.RAD_W(RAD_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_vld  (op_vld),
    .op_rad  (op_rad),
    .res_vld (res_vld),
    .res_root(res_root),
    .res_rem (res_rem)
);

// File: tb/tb_sqrt_pipe.sv
module tb_sqrt_pipe;
    localparam int RAD_W  = 32;
    localparam int ROOT_W = RAD_W / 2;
    localparam int REM_W  = ROOT_W + 2;
    localparam int LAT    = ROOT_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              op_vld = 1'b0;
    logic [RAD_W-1:0]  op_rad = '0;
    logic              res_vld;
    logic [ROOT_W-1:0] res_root;
    logic [REM_W-1:0]  res_rem;

    int checks = 0;
    int fails  = 0;
    int burst_seen = 0;
    logic             mdl_v [LAT];
    logic [RAD_W-1:0] mdl_x [LAT];

    always #2 clk = ~clk;

    sqrt_pipe #(.RAD_W(RAD_W)) dut (
        .clk(clk), .rst(rst), .op_vld(op_vld), .op_rad(op_rad),
        .res_vld(res_vld), .res_root(res_root), .res_rem(res_rem)
    );

    function automatic longint unsigned ref_root(input longint unsigned x);
        longint unsigned lo = 0, hi = (64'd1 << ROOT_W) - 1, mid;
        while (lo < hi) begin
            mid = (lo + hi + 1) / 2;
            if (mid * mid <= x) lo = mid;
            else hi = mid - 1;
        end
        return lo;
    endfunction

    task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive at falling edge, update model at rising edge, check at next falling edge
    task automatic tick(input logic v, input logic [RAD_W-1:0] x);
        longint unsigned r;
        op_vld = v;
        op_rad = x;
        @(posedge clk);
        for (int i = LAT - 1; i > 0; i--) begin
            mdl_v[i] = mdl_v[i-1];
            mdl_x[i] = mdl_x[i-1];
        end
        mdl_v[0] = v;
        mdl_x[0] = x;
        if (rst) for (int i = 0; i < LAT; i++) mdl_v[i] = 1'b0;
        @(negedge clk);
        check("R3 valid", res_vld, mdl_v[LAT-1]);
        if (res_vld) burst_seen++;
        if (mdl_v[LAT-1]) begin
            r = ref_root(mdl_x[LAT-1]);
            check("R1 root", res_root, r);
            check("R2 rem", res_rem, mdl_x[LAT-1] - r * r);
        end
    endtask

    task automatic run_one(input string req, input logic [RAD_W-1:0] x,
                           input longint unsigned er, input longint unsigned em);
        tick(1'b1, x);
        for (int i = 1; i < LAT; i++) tick(1'b0, '0);
        check({req, " root"}, res_root, er);
        check({req, " rem"}, res_rem, em);
        tick(1'b0, '0);
    endtask

    initial begin
        longint unsigned k;
        logic [RAD_W-1:0] x;
        for (int i = 0; i < LAT; i++) begin mdl_v[i] = 1'b0; mdl_x[i] = '0; end
        void'($urandom(32'd1234));
        @(negedge clk);
        for (int i = 0; i < 3; i++) tick(1'b0, '0);
        rst = 1'b0;
        check("R5 reset", res_vld, 0);

        run_one("R7 zero", '0, 0, 0);
        run_one("R7 ninety-three", RAD_W'(93), 9, 12);
        run_one("R7 all-ones", '1, (64'd1 << ROOT_W) - 1, (64'd1 << (ROOT_W + 1)) - 2);
        run_one("R8 square", RAD_W'(65536), 256, 0);
        run_one("R8 below-square", RAD_W'(65535), 255, 510);
        k = 64'hFFFF;
        run_one("R8 max-square", RAD_W'(k * k), k, 0);
        run_one("R8 below-max-square", RAD_W'(k * k - 1), k - 1, 2 * k - 2);

        // R6: idle operands must not produce strobes
        for (int i = 0; i < 2 * LAT; i++) tick(1'b0, RAD_W'($urandom));
        check("R6 idle", res_vld, 0);

        // R4: back-to-back burst
        burst_seen = 0;
        for (int i = 0; i < 500; i++) begin
            k = longint'($urandom) & 64'hFFFF;
            case ($urandom % 4)
                0: x = RAD_W'(k * k);
                1: x = RAD_W'(k * k + 2 * k);
                default: x = RAD_W'($urandom);
            endcase
            tick(1'b1, x);
        end
        for (int i = 0; i < LAT; i++) tick(1'b0, '0);
        check("R4 burst count", burst_seen, 500);

        // random strobes
        for (int i = 0; i < 3000; i++) tick(1'($urandom % 3 != 0), RAD_W'($urandom));

        // R5: reset with a full pipe
        for (int i = 0; i < LAT; i++) tick(1'b1, RAD_W'($urandom));
        rst = 1'b1;
        tick(1'b1, RAD_W'($urandom));
        rst = 1'b0;
        check("R5 mid-run reset", res_vld, 0);
        for (int i = 0; i < LAT; i++) tick(1'b0, '0);
        check("R5 drained", res_vld, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule